// File: doc/BRIEF.md
# NAND Flash Transaction Sequencer

This block turns one operation request from a processor-side buffer into a complete bus transaction on an asynchronous, byte-wide NAND flash device. It handles six operations: device reset, identifier read, page read, page program, block erase and status read. For each one it emits the command, address and data bytes with the right latch strobes. It waits on the device's ready/busy line and moves page data between the device and the request buffer. Every device timing rule is enforced here, so the requester only writes a request and waits for the completion pulse.

The requester places an operation code and a 40-bit address on the request inputs and pulses `start`. Write data is fetched from the buffer by index (`buf_idx` / `buf_wdata`). Returned bytes are written back through `buf_we` / `buf_rdata` at the same index. After a program, erase or reset the sequencer reads status by itself and reports the pass/fail result with the `done` pulse. Strobe low and high widths come from two run-time cycle counts.

Top module: `nand_cmd_engine`

## Requirements
- R1: Out of reset, and whenever idle, the chip select, write strobe and read strobe are high, the write-protect output and both latch enables are low, the I/O driver is off, and `busy` and `done` are low.
- R2: Operation code 3 (program) sends command 0x80 and then address bytes 0 to 4. Address byte k is `addr[8k+7:8k]`. Next come PAGE_BYTES data bytes taken from buffer indices 0 upward, then command 0x10. The write-protect output is high for the whole transaction.
- R3: Operation code 2 (page read) sends 0x00, address bytes 0 to 4 and 0x30. It then waits for ready and performs PAGE_BYTES read strobes. Byte n is written to buffer index n.
- R4: Operation code 4 (erase) sends 0x60, then only address bytes 2, 3 and 4, then 0xD0. The write-protect output is high for the whole transaction.
- R5: Operation code 0 (reset) sends 0xFF. Operation code 1 (identifier read) sends 0x90 and one 0x00 address byte, then performs ID_BYTES reads into buffer indices 0 upward.
- R6: Operation code 5 (status) sends 0x70 and performs one read. The byte goes to buffer index 0 and to `status_out`.
- R7: After program, erase or reset, the sequencer waits for ready and then sends 0x70 and reads one status byte. `pass` at `done` is 1 exactly when bit 0 of that byte is 0. For the status operation `pass` follows the same rule. For the two read operations `pass` is 1.
- R8: The command latch enable is high only while command bytes are strobed, and the address latch enable only while address bytes are strobed; the two are never high together. Outside program and erase the write-protect output is low.
- R9: Each write or read strobe stays low for `t_low` clock cycles, with a value of 0 counting as 1. Between two consecutive strobes both strobes stay high for at least `t_high` cycles, again with 0 counting as 1. The write and read strobes are never low together, and the I/O driver is never on while the read strobe is low.
- R10: No strobe is issued while ready/busy is low. After a confirm command the sequencer waits RB_GUARD cycles before it samples ready. Once ready is seen, the first read strobe of a page read falls one cycle later.
- R11: `done` is a one-cycle pulse and `busy` drops right after it. A `start` while busy is ignored, and so is a `start` with an operation code of 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted when idle |
| op | input | 3 | Operation code (0 reset, 1 identifier, 2 read, 3 program, 4 erase, 5 status) |
| addr | input | 40 | Five address bytes, byte k at bits 8k+7:8k |
| t_low | input | TW | Strobe low width in cycles |
| t_high | input | TW | Strobe high width in cycles |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid with `done` |
| status_out | output | 8 | Last status byte read |
| buf_idx | output | IW | Buffer index for write fetch or read return |
| buf_wdata | input | 8 | Buffer byte at `buf_idx` |
| buf_we | output | 1 | Buffer write strobe for a returned byte |
| buf_rdata | output | 8 | Returned byte |
| nand_ce_n | output | 1 | Chip select, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, data latched on its rising edge |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, high allows program/erase |
| nand_io_out | output | 8 | Bus value driven to the device |
| nand_io_oe | output | 1 | Bus driver enable |
| nand_io_in | input | 8 | Bus value from the device |
| nand_rb | input | 1 | Ready (high) / busy (low) |

## Verification
Every bus byte completes when its write strobe rises, which is `t_low` cycles after the strobe falls. The bench samples all pins on the falling clock edge, measures the low and high widths in whole cycles, and pops the expected command, address or data byte only at that rise. A returned byte is due in the last low cycle of its read strobe, which is the one cycle in which `buf_we` is high, and it is compared with index and value there. After the device model releases ready, the first read strobe is expected exactly one cycle later. `done` is sampled in the cycle after the final strobe's high phase ends, and `busy` must be low in the following cycle.

// File: rtl/nand_cmd_engine.sv
`timescale 1ns/1ps
module nand_cmd_engine #(
  parameter int PAGE_BYTES = 2112,
  parameter int ID_BYTES   = 4,
  parameter int RB_GUARD   = 8,
  parameter int TW         = 4,
  localparam int IW = $clog2(PAGE_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [39:0]   addr,
  input  logic [TW-1:0] t_low,
  input  logic [TW-1:0] t_high,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic [7:0]    status_out,
  output logic [IW-1:0] buf_idx,
  input  logic [7:0]    buf_wdata,
  output logic          buf_we,
  output logic [7:0]    buf_rdata,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic          nand_wp_n,
  output logic [7:0]    nand_io_out,
  output logic          nand_io_oe,
  input  logic [7:0]    nand_io_in,
  input  logic          nand_rb
);
  localparam int GW = $clog2(RB_GUARD + 1);
  localparam logic [2:0] OP_RST = 3'd0, OP_RID = 3'd1, OP_RD = 3'd2,
                         OP_PRG = 3'd3, OP_ERS = 3'd4, OP_STS = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_ADDR, S_WDAT, S_CONF, S_WAIT, S_RDAT, S_SCMD, S_SRD, S_DONE
  } st_t;

  st_t           st;
  logic [2:0]    op_q;
  logic [39:0]   addr_q;
  logic          ph;
  logic [TW-1:0] tcnt;
  logic [IW-1:0] idx;
  logic [GW-1:0] gcnt;
  logic [7:0]    status_q;
  logic          pass_q;

  logic [TW-1:0] lo_lim, hi_lim;
  logic          strobe_w, strobe_r, strobe, end_lo, end_hi;
  logic [IW-1:0] addr_first, addr_last, rd_last;
  logic [39:0]   a_sh;

  assign lo_lim   = (t_low  == '0) ? TW'(1) : t_low;
  assign hi_lim   = (t_high == '0) ? TW'(1) : t_high;
  assign strobe_w = (st == S_CMD) || (st == S_ADDR) || (st == S_WDAT) ||
                    (st == S_CONF) || (st == S_SCMD);
  assign strobe_r = (st == S_RDAT) || (st == S_SRD);
  assign strobe   = strobe_w || strobe_r;
  assign end_lo   = strobe && !ph && (tcnt == lo_lim - TW'(1));
  assign end_hi   = strobe &&  ph && (tcnt == hi_lim - TW'(1));

  assign addr_first = (op_q == OP_ERS) ? IW'(2) : IW'(0);
  assign addr_last  = (op_q == OP_RID) ? IW'(0) : IW'(4);
  assign rd_last    = (op_q == OP_RID) ? IW'(ID_BYTES - 1) : IW'(PAGE_BYTES - 1);
  assign a_sh       = addr_q >> {idx[2:0], 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_q     <= OP_RST;
      addr_q   <= '0;
      ph       <= 1'b0;
      tcnt     <= '0;
      idx      <= '0;
      gcnt     <= '0;
      status_q <= '0;
      pass_q   <= 1'b0;
    end else begin
      if (!strobe || end_lo || end_hi) begin
        tcnt <= '0;
        ph   <= strobe && end_lo;
      end else begin
        tcnt <= tcnt + TW'(1);
      end
      unique case (st)
        S_IDLE: if (start && op <= OP_STS) begin
          op_q   <= op;
          addr_q <= addr;
          pass_q <= 1'b0;
          idx    <= '0;
          st     <= (op == OP_STS) ? S_SCMD : S_CMD;
        end
        S_CMD: if (end_hi) begin
          if (op_q == OP_RST) begin
            st   <= S_WAIT;
            gcnt <= '0;
          end else begin
            st  <= S_ADDR;
            idx <= addr_first;
          end
        end
        S_ADDR: if (end_hi) begin
          if (idx == addr_last) begin
            idx <= '0;
            case (op_q)
              OP_RID:  st <= S_RDAT;
              OP_PRG:  st <= S_WDAT;
              default: st <= S_CONF;
            endcase
          end else begin
            idx <= idx + IW'(1);
          end
        end
        S_WDAT: if (end_hi) begin
          if (idx == IW'(PAGE_BYTES - 1)) st <= S_CONF;
          else idx <= idx + IW'(1);
        end
        S_CONF: if (end_hi) begin
          st   <= S_WAIT;
          gcnt <= '0;
        end
        S_WAIT: begin
          if (gcnt != GW'(RB_GUARD)) gcnt <= gcnt + GW'(1);
          else if (nand_rb) begin
            idx <= '0;
            st  <= (op_q == OP_RD) ? S_RDAT : S_SCMD;
          end
        end
        S_RDAT: if (end_hi) begin
          if (idx == rd_last) begin
            st     <= S_DONE;
            pass_q <= 1'b1;
          end else begin
            idx <= idx + IW'(1);
          end
        end
        S_SCMD: if (end_hi) begin
          st  <= S_SRD;
          idx <= '0;
        end
        S_SRD: begin
          if (end_lo) begin
            status_q <= nand_io_in;
            pass_q   <= !nand_io_in[0];
          end
          if (end_hi) st <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_CMD: case (op_q)
        OP_RST:  nand_io_out = 8'hFF;
        OP_RID:  nand_io_out = 8'h90;
        OP_RD:   nand_io_out = 8'h00;
        OP_PRG:  nand_io_out = 8'h80;
        default: nand_io_out = 8'h60;
      endcase
      S_CONF: case (op_q)
        OP_RD:   nand_io_out = 8'h30;
        OP_PRG:  nand_io_out = 8'h10;
        default: nand_io_out = 8'hD0;
      endcase
      S_ADDR:  nand_io_out = (op_q == OP_RID) ? 8'h00 : a_sh[7:0];
      S_WDAT:  nand_io_out = buf_wdata;
      S_SCMD:  nand_io_out = 8'h70;
      default: nand_io_out = 8'h00;
    endcase
  end

  assign busy       = (st != S_IDLE);
  assign done       = (st == S_DONE);
  assign pass       = pass_q;
  assign status_out = status_q;
  assign buf_idx    = idx;
  assign buf_we     = end_lo && ((st == S_RDAT) || (st == S_SRD && op_q == OP_STS));
  assign buf_rdata  = nand_io_in;
  assign nand_ce_n  = (st == S_IDLE) || (st == S_DONE);
  assign nand_cle   = (st == S_CMD) || (st == S_CONF) || (st == S_SCMD);
  assign nand_ale   = (st == S_ADDR);
  assign nand_we_n  = !(strobe_w && !ph);
  assign nand_re_n  = !(strobe_r && !ph);
  assign nand_wp_n  = busy && ((op_q == OP_PRG) || (op_q == OP_ERS));
  assign nand_io_oe = strobe_w;

  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_wp_n && !nand_io_oe));
  a_r8_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  a_r8_cle_drives: assert property (@(posedge clk) disable iff (!rst_n)
    nand_cle |-> (nand_io_oe && !nand_ce_n));
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe);
  a_r10_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_rb |-> (nand_we_n && nand_re_n));
  a_r3_capture_low: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !nand_re_n);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  a_r11_start_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/test_nand_cmd_engine.sv
`timescale 1ns/1ps
module test_nand_cmd_engine;
  localparam int PAGE = 2112, IDN = 4, BUSYC = 20, TW = 4;
  localparam int IW = $clog2(PAGE + 1);
  localparam logic [2:0] OP_RST = 3'd0, OP_RID = 3'd1, OP_RD = 3'd2,
                         OP_PRG = 3'd3, OP_ERS = 3'd4, OP_STS = 3'd5;
  localparam int M_STS = 0, M_ID = 1, M_PG = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] op_i = '0;
  logic [39:0] addr_i = '0;
  logic [TW-1:0] t_low = TW'(1), t_high = TW'(1);
  logic busy, done, pass, buf_we, ce_n, cle, ale, we_n, re_n, wp_n, io_oe;
  logic [7:0] status_out, buf_wdata, buf_rdata, io_out, io_in;
  logic [IW-1:0] buf_idx;
  logic rb;

  int checks = 0, errors = 0;
  string cur_tag = "R1";
  int lo_exp = 1, hi_exp = 1;
  logic sfail = 1'b0;
  int mode = M_STS, ptr = 0, rbcnt = 0, cyc = 0;
  int wl = 0, rl = 0, hl = 0, viol = 0;
  int rb_rise_cyc = 0, first_re = 0;
  logic [10:0] hold = '0;
  logic [10:0] wq[$];
  logic [23:0] rq[$];

  function automatic logic [7:0] wpat(int i);
    return 8'((i * 5 + 1) ^ (i >> 4));
  endfunction
  function automatic logic [7:0] rpat(int i);
    return 8'((i * 3 + 7) ^ (i >> 5));
  endfunction

  assign buf_wdata = wpat(int'(buf_idx));
  assign rb = (rbcnt == 0);
  assign io_in = (mode == M_STS) ? (8'hE0 | {7'd0, sfail}) :
                 (mode == M_ID)  ? 8'(8'h2C + ptr) : rpat(ptr);

  nand_cmd_engine #(.PAGE_BYTES(PAGE), .ID_BYTES(IDN), .RB_GUARD(8), .TW(TW)) i_nand_cmd_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .addr(addr_i),
    .t_low(t_low), .t_high(t_high), .busy(busy), .done(done), .pass(pass),
    .status_out(status_out), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
    .buf_we(buf_we), .buf_rdata(buf_rdata), .nand_ce_n(ce_n), .nand_cle(cle),
    .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n), .nand_wp_n(wp_n),
    .nand_io_out(io_out), .nand_io_oe(io_oe), .nand_io_in(io_in), .nand_rb(rb));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // monitor and device model, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rbcnt > 0) begin
      rbcnt--;
      if (rbcnt == 0) begin rb_rise_cyc = cyc; first_re = -1; end
    end
    if (rbcnt > 0 && (!we_n || !re_n)) viol++;
    if (!busy) hl = 0;
    if ((!we_n && wl == 0) || (!re_n && rl == 0)) begin
      if (hl > 0) chk(hl >= hi_exp, "R9 high width", hl, hi_exp);
      hl = 0;
    end
    if (!re_n && rl == 0 && first_re < 0) first_re = cyc;
    if (buf_we) begin
      if (rq.size() == 0) chk(1'b0, {cur_tag, " extra return"}, buf_rdata, 0);
      else begin
        logic [23:0] e;
        e = rq.pop_front();
        chk({8'(buf_idx), buf_rdata} == {e[23:8], e[7:0]} || ({16'(buf_idx), buf_rdata} == e),
            {cur_tag, " returned byte"}, {16'(buf_idx), buf_rdata}, e);
      end
    end
    if (!we_n) begin
      wl++;
      hold = {wp_n, cle, ale, io_out};
    end else if (wl > 0) begin
      chk(wl == lo_exp, "R9 write low width", wl, lo_exp);
      if (wq.size() == 0) chk(1'b0, {cur_tag, " extra bus byte"}, hold, 0);
      else begin
        logic [10:0] e;
        e = wq.pop_front();
        chk(hold == e, {cur_tag, " R8 bus byte"}, hold, e);
      end
      if (hold[9]) begin
        case (hold[7:0])
          8'h70: mode = M_STS;
          8'h90: begin mode = M_ID; ptr = 0; end
          8'h30: begin mode = M_PG; ptr = 0; rbcnt = BUSYC; end
          8'h10, 8'hD0, 8'hFF: rbcnt = BUSYC;
          default: ;
        endcase
      end
      wl = 0;
    end
    if (!re_n) rl++;
    else if (rl > 0) begin
      chk(rl == lo_exp, "R9 read low width", rl, lo_exp);
      ptr++;
      rl = 0;
    end
    if (busy && we_n && re_n) hl++;
  end

  task automatic push_w(input bit wp, input bit c, input bit a, input logic [7:0] d);
    wq.push_back({wp, c, a, d});
  endtask

  task automatic set_tim(input int lo, input int hi);
    t_low = TW'(lo); t_high = TW'(hi);
    lo_exp = (lo == 0) ? 1 : lo;
    hi_exp = (hi == 0) ? 1 : hi;
  endtask

  task automatic run_op(input logic [2:0] o, input logic [39:0] a, input bit fail,
                        input bit inject, input string tag);
    bit exp_pass;
    bit wp;
    cur_tag = tag;
    sfail = fail;
    wp = (o == OP_PRG) || (o == OP_ERS);
    exp_pass = 1'b1;
    case (o)
      OP_RST: begin push_w(0, 1, 0, 8'hFF); push_w(0, 1, 0, 8'h70); exp_pass = !fail; end
      OP_RID: begin
        push_w(0, 1, 0, 8'h90); push_w(0, 0, 1, 8'h00);
        for (int i = 0; i < IDN; i++) rq.push_back({16'(i), 8'(8'h2C + i)});
      end
      OP_RD: begin
        push_w(0, 1, 0, 8'h00);
        for (int k = 0; k < 5; k++) push_w(0, 0, 1, a[8*k +: 8]);
        push_w(0, 1, 0, 8'h30);
        for (int i = 0; i < PAGE; i++) rq.push_back({16'(i), rpat(i)});
      end
      OP_PRG: begin
        push_w(1, 1, 0, 8'h80);
        for (int k = 0; k < 5; k++) push_w(1, 0, 1, a[8*k +: 8]);
        for (int i = 0; i < PAGE; i++) push_w(1, 0, 0, wpat(i));
        push_w(1, 1, 0, 8'h10); push_w(1, 1, 0, 8'h70);
        exp_pass = !fail;
      end
      OP_ERS: begin
        push_w(1, 1, 0, 8'h60);
        for (int k = 2; k < 5; k++) push_w(1, 0, 1, a[8*k +: 8]);
        push_w(1, 1, 0, 8'hD0); push_w(1, 1, 0, 8'h70);
        exp_pass = !fail;
      end
      default: begin
        push_w(0, 1, 0, 8'h70);
        rq.push_back({16'd0, 8'hE0 | {7'd0, fail}});
        exp_pass = !fail;
      end
    endcase
    @(negedge clk); op_i = o; addr_i = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (inject) begin
      repeat (30) @(negedge clk);
      op_i = OP_ERS; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b1, "R11 busy during ignored start", busy, 1);
    end
    while (!done) @(negedge clk);
    chk(pass == exp_pass, {tag, " R7 pass"}, pass, exp_pass);
    if (o == OP_STS || wp || o == OP_RST)
      chk(status_out == (8'hE0 | {7'd0, fail}), {tag, " R6 status_out"}, status_out, 8'hE0 | {7'd0, fail});
    @(negedge clk);
    chk(!busy && !done, "R11 done one cycle then idle", {busy, done}, 0);
    chk(wq.size() == 0, {tag, " missing bus bytes"}, wq.size(), 0);
    chk(rq.size() == 0, {tag, " missing returns"}, rq.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({ce_n, we_n, re_n, wp_n, cle, ale, io_oe, busy, done} == 9'b111000000,
        "R1 reset pins", {ce_n, we_n, re_n, wp_n, cle, ale, io_oe, busy, done}, 9'b111000000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    set_tim(1, 1);
    run_op(OP_STS, 40'd0, 1'b0, 1'b0, "R6");
    run_op(OP_STS, 40'd0, 1'b1, 1'b0, "R6");
    run_op(OP_RST, 40'd0, 1'b0, 1'b0, "R5");
    run_op(OP_RID, 40'd0, 1'b0, 1'b0, "R5");
    set_tim(2, 1);
    run_op(OP_PRG, 40'hA5_3C_12_07_40, 1'b0, 1'b0, "R2");
    set_tim(3, 2);
    run_op(OP_RD, 40'h01_02_03_04_05, 1'b0, 1'b1, "R3");
    chk(first_re - rb_rise_cyc == 1, "R10 ready to first read strobe", first_re - rb_rise_cyc, 1);
    chk(viol == 0, "R10 strobe while busy", viol, 0);
    set_tim(0, 0);
    run_op(OP_ERS, 40'h77_66_55_44_33, 1'b0, 1'b0, "R4");
    run_op(OP_ERS, 40'h11_22_33_44_55, 1'b1, 1'b0, "R4");
    set_tim(1, 2);
    run_op(OP_PRG, 40'h00_00_01_00_00, 1'b1, 1'b0, "R7");
    run_op(OP_RST, 40'd0, 1'b1, 1'b0, "R7");
    @(negedge clk); op_i = 3'd7; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(!busy && ce_n && !wp_n, "R11 unsupported code ignored", {busy, ce_n, wp_n}, 3'b010);
    end
    chk(wq.size() == 0 && viol == 0, "R8 R10 final", viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule